// File: doc/BRIEF.md
# Byte-Stream to Aligned Word Write Packer

This block sits between a byte-oriented write client and a flash word programmer that only accepts whole 32-bit words at word-aligned addresses. A client posts one request made of a byte start address and a byte length. It then streams the data bytes over a valid/ready port. The block assembles them into aligned words and hands each word to the programmer over a request/acknowledge port. The programmer returns a pass flag with its acknowledge.

A program operation on flash can only clear bits. Byte lanes that the request does not cover are therefore filled with all-ones, which leaves the stored contents of those lanes unchanged. The block keeps a running count of the request bytes that landed in successfully programmed words. It ends the request at the first word the programmer reports as failed. Zero-length requests finish immediately. Requests that would run past the end of the device are refused before any word is issued.

Top module: `flash_write_packer`

## Requirements
- R1: Every word request carries an address whose two low bits are zero. The first word goes to the start address rounded down to a multiple of 4, and each further word goes to the previous word address plus 4.
- R2: Lane order is little-endian: bits [8k+7:8k] of a word hold the byte at word address + k. In the first word of a request with an unaligned start, the lanes below the start offset read 8'hFF and the following lanes carry request bytes in stream order.
- R3: Between the head and the tail, each word carries four consecutive stream bytes with no padding.
- R4: The final word of a request carries the remaining bytes in its lowest lanes, and its lanes above them read 8'hFF.
- R5: A request that begins and ends inside one word produces exactly one word request, padded with 8'hFF on both sides.
- R6: `byte_count` starts at 0 when a request is accepted. It rises only on an acknowledge with pass set, and only by the number of request bytes in that word, never counting padding lanes.
- R7: An acknowledge with pass clear ends the request. `done` pulses with `status` = 2'b01 (I/O error), no further word request follows, and the failed word's bytes are not counted.
- R8: A request with length 0 raises `done` on the cycle after acceptance with `status` = 2'b00 (ok), `byte_count` = 0 and no word request.
- R9: A request whose start address plus length exceeds DEV_BYTES raises `done` on the cycle after acceptance with `status` = 2'b10 (invalid) and no word request. Ending exactly at DEV_BYTES is allowed.
- R10: Once raised, `wr_req` stays high with a stable address and data until `wr_ack`. `byte_ready` is low while `wr_req` is high, so stream bytes are neither taken nor lost during a word request.
- R11: A completed request without failure raises `done` for one cycle with `status` = 2'b00 and returns to idle. `req_ready` is high only when idle. After reset the block is idle with `wr_req`, `done` and `byte_count` at 0 and `status` at 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken when both high |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | LEN_W | Byte length |
| byte_valid | input | 1 | Stream byte offered |
| byte_ready | output | 1 | Stream byte taken when both high |
| byte_data | input | 8 | Stream byte |
| wr_req | output | 1 | Word program request |
| wr_addr | output | ADDR_W | Word address, 4-byte aligned |
| wr_data | output | 8*BUS_BYTES | Word data, lane 0 lowest address |
| wr_ack | input | 1 | Programmer finished the word |
| wr_pass | input | 1 | Word programmed correctly (valid with wr_ack) |
| done | output | 1 | One-cycle end-of-request pulse |
| status | output | 2 | 00 ok, 01 I/O error, 10 invalid; held until next request |
| byte_count | output | LEN_W | Request bytes in passed words |

## Verification
A stream byte is taken on the edge where `byte_valid` and `byte_ready` are both high. The word it completes appears on `wr_req` directly after that edge. An acknowledge edge produces either the next fill phase or the `done` pulse one cycle later. A zero-length or out-of-range request produces `done` on the first edge after acceptance. The bench drives and samples only at falling edges. It holds each acknowledge back by one cycle, so it can confirm that the word stays stable. It then reads `status` and `byte_count` at the falling edge where `done` is first seen. It predicts every word, the count and the status from the address, the length and the injected failure index.

// File: rtl/flash_write_packer_pkg.sv
package flash_write_packer_pkg;

    typedef enum logic [1:0] {
        PK_IDLE = 2'd0,
        PK_FILL = 2'd1,
        PK_PROG = 2'd2
    } pk_state_t;

    typedef enum logic [1:0] {
        RES_OK      = 2'b00,
        RES_IOERR   = 2'b01,
        RES_INVALID = 2'b10
    } pk_result_t;

endpackage

// File: rtl/packer_range_check.sv
module packer_range_check #(
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 16,
    parameter int DEV_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              is_empty,
    output logic              is_overrun
);
    localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 2;
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'(DEV_BYTES);

    logic [SUM_W-1:0] end_excl;

    always_comb begin
        end_excl   = SUM_W'(addr) + SUM_W'(len);
        is_empty   = (len == '0);
        is_overrun = (end_excl > LIMIT);
    end
endmodule

// File: rtl/packer_lane_insert.sv
module packer_lane_insert #(
    parameter int BUS_BYTES = 4,
    localparam int LANE_W   = $clog2(BUS_BYTES),
    localparam int DATA_W   = 8 * BUS_BYTES
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        byte_in,
    output logic [DATA_W-1:0] word_out
);
    for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
        assign word_out[8*g +: 8] = (lane == LANE_W'(g)) ? byte_in : word_in[8*g +: 8];
    end
endmodule

// File: rtl/flash_write_packer.sv
module flash_write_packer
    import flash_write_packer_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 16,
    parameter int DEV_BYTES = 4096,
    parameter int BUS_BYTES = 4,
    localparam int LANE_W   = $clog2(BUS_BYTES),
    localparam int DATA_W   = 8 * BUS_BYTES,
    localparam int TAKE_W   = LANE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic [7:0]        byte_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack,
    input  logic              wr_pass,
    output logic              done,
    output logic [1:0]        status,
    output logic [LEN_W-1:0]  byte_count
);
    typedef struct packed {
        pk_state_t         state;
        logic [ADDR_W-1:0] waddr;
        logic [LANE_W-1:0] lane;
        logic [LEN_W-1:0]  rem;
        logic [TAKE_W-1:0] taken;
        logic [DATA_W-1:0] wbuf;
        logic [LEN_W-1:0]  count;
        logic              done;
        pk_result_t        result;
    } pk_regs_t;

    pk_regs_t r_q, r_d;

    logic              chk_empty, chk_overrun;
    logic [DATA_W-1:0] wbuf_ins;

    packer_range_check #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES)
    ) u_range (
        .addr(req_addr), .len(req_len),
        .is_empty(chk_empty), .is_overrun(chk_overrun)
    );

    packer_lane_insert #(.BUS_BYTES(BUS_BYTES)) u_insert (
        .word_in(r_q.wbuf), .lane(r_q.lane), .byte_in(byte_data),
        .word_out(wbuf_ins)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            PK_IDLE: begin
                if (req_valid) begin
                    r_d.count = '0;
                    if (chk_empty) begin
                        r_d.done   = 1'b1;
                        r_d.result = RES_OK;
                    end else if (chk_overrun) begin
                        r_d.done   = 1'b1;
                        r_d.result = RES_INVALID;
                    end else begin
                        r_d.state  = PK_FILL;
                        r_d.waddr  = {req_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                        r_d.lane   = req_addr[LANE_W-1:0];
                        r_d.rem    = req_len;
                        r_d.taken  = '0;
                        r_d.wbuf   = '1;
                        r_d.result = RES_OK;
                    end
                end
            end
            PK_FILL: begin
                if (byte_valid) begin
                    r_d.wbuf  = wbuf_ins;
                    r_d.rem   = r_q.rem - 1'b1;
                    r_d.taken = r_q.taken + 1'b1;
                    r_d.lane  = r_q.lane + 1'b1;
                    if (r_q.lane == LANE_W'(BUS_BYTES - 1) || r_q.rem == LEN_W'(1)) begin
                        r_d.state = PK_PROG;
                    end
                end
            end
            PK_PROG: begin
                if (wr_ack) begin
                    if (!wr_pass) begin
                        r_d.state  = PK_IDLE;
                        r_d.done   = 1'b1;
                        r_d.result = RES_IOERR;
                    end else begin
                        r_d.count = r_q.count + LEN_W'(r_q.taken);
                        if (r_q.rem == '0) begin
                            r_d.state = PK_IDLE;
                            r_d.done  = 1'b1;
                        end else begin
                            r_d.state = PK_FILL;
                            r_d.waddr = r_q.waddr + ADDR_W'(BUS_BYTES);
                            r_d.lane  = '0;
                            r_d.taken = '0;
                            r_d.wbuf  = '1;
                        end
                    end
                end
            end
            default: r_d.state = PK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= PK_IDLE;
            r_q.wbuf   <= '1;
            r_q.result <= RES_OK;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.state == PK_IDLE);
    assign byte_ready = (r_q.state == PK_FILL);
    assign wr_req     = (r_q.state == PK_PROG);
    assign wr_addr    = r_q.waddr;
    assign wr_data    = r_q.wbuf;
    assign done       = r_q.done;
    assign status     = r_q.result;
    assign byte_count = r_q.count;
endmodule

// File: rtl/flash_write_packer_checker.sv
module flash_write_packer_checker #(
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 16,
    parameter int BUS_BYTES = 4,
    localparam int LANE_W   = $clog2(BUS_BYTES),
    localparam int DATA_W   = 8 * BUS_BYTES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              byte_ready,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_ack,
    input logic              wr_pass,
    input logic              done,
    input logic [LEN_W-1:0]  byte_count
);
    p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_addr[LANE_W-1:0] == '0));

    p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    p_no_byte_in_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !byte_ready);

    p_count_on_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_req && wr_ack && wr_pass) && !(req_valid && req_ready)) |=> $stable(byte_count));

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_on_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !wr_req));
endmodule

bind flash_write_packer flash_write_packer_checker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .byte_ready(byte_ready), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .wr_pass(wr_pass), .done(done),
    .byte_count(byte_count)
);

// File: tb/flash_write_packer_test.sv
module flash_write_packer_test;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 16;
    localparam int DEVB   = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              byte_valid = 1'b0;
    logic              byte_ready;
    logic [7:0]        byte_data = '0;
    logic              wr_req;
    logic [ADDR_W-1:0] wr_addr;
    logic [31:0]       wr_data;
    logic              wr_ack = 1'b0;
    logic              wr_pass = 1'b0;
    logic              done;
    logic [1:0]        status;
    logic [LEN_W-1:0]  byte_count;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    flash_write_packer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEV_BYTES(DEVB)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .byte_valid(byte_valid),
        .byte_ready(byte_ready), .byte_data(byte_data), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .wr_pass(wr_pass),
        .done(done), .status(status), .byte_count(byte_count)
    );

    // {addr[15:0], len[11:0], fail_word[3:0]}; fail_word 4'hF means no failure
    localparam int NV = 11;
    localparam logic [31:0] VEC [NV] = '{
        {16'd0,    12'd8,  4'hF},   // R3 two full words
        {16'd1,    12'd2,  4'hF},   // R5 padded both sides
        {16'd3,    12'd6,  4'hF},   // R2 head, R4 tail
        {16'd2,    12'd1,  4'hF},   // R5 single byte
        {16'd5,    12'd11, 4'hF},   // R2 R3 R4
        {16'd8,    12'd4,  4'hF},   // R3 exactly one word
        {16'd6,    12'd9,  4'h1},   // R7 second word fails
        {16'd0,    12'd4,  4'h0},   // R7 first word fails
        {16'd4094, 12'd2,  4'hF},   // R9 ends at device size
        {16'd13,   12'd3,  4'hF},   // R2 ends on word end
        {16'd20,   12'd13, 4'h3}    // R7 fail on tail word
    };

    function automatic logic [7:0] pat(int v, int k);
        return 8'((v * 37 + k * 11 + 5) & 8'hFF);
    endfunction

    function automatic logic [31:0] exp_word(int a, int l, int v, int i);
        logic [31:0] w;
        int base;
        base = (a / 4) * 4 + 4 * i;
        for (int ln = 0; ln < 4; ln++) begin
            if (base + ln >= a && base + ln < a + l) w[8*ln +: 8] = pat(v, base + ln - a);
            else w[8*ln +: 8] = 8'hFF;
        end
        return w;
    endfunction

    function automatic int real_bytes(int a, int l, int i);
        int base, n;
        base = (a / 4) * 4 + 4 * i;
        n = 0;
        for (int ln = 0; ln < 4; ln++)
            if (base + ln >= a && base + ln < a + l) n++;
        return n;
    endfunction

    task automatic check(bit ok, string req, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic run_req(int a, int l, int fail_at, int v);
        int k, widx, nwords, exp_cnt, iter;
        bit pending, seen_done, side_ok;
        logic [31:0] hold_d;
        logic [ADDR_W-1:0] hold_a;
        nwords  = (l == 0) ? 0 : ((a + l - 1) / 4 - a / 4 + 1);
        exp_cnt = 0;
        for (int i = 0; i < nwords && i < fail_at; i++) exp_cnt += real_bytes(a, l, i);
        k = 0; widx = 0; pending = 0; seen_done = 0; side_ok = 1;
        hold_d = '0; hold_a = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = ADDR_W'(a); req_len = LEN_W'(l);
        @(negedge clk);
        req_valid = 1'b0;
        for (iter = 0; iter < 400; iter++) begin
            if (done) begin seen_done = 1; break; end
            if (wr_req && byte_ready) side_ok = 0;
            if (byte_ready && k < l) begin
                byte_valid = 1'b1; byte_data = pat(v, k); k++;
            end else begin
                byte_valid = 1'b0;
            end
            if (wr_req) begin
                if (!pending) begin
                    check(wr_addr == ADDR_W'((a / 4) * 4 + 4 * widx), "R1", wr_addr, (a / 4) * 4 + 4 * widx);
                    check(wr_data == exp_word(a, l, v, widx), "R2/R3/R4", wr_data, exp_word(a, l, v, widx));
                    hold_d = wr_data; hold_a = wr_addr;
                    pending = 1; wr_ack = 1'b0;
                end else begin
                    if (wr_data != hold_d || wr_addr != hold_a) side_ok = 0;
                    wr_ack = 1'b1; wr_pass = (widx != fail_at);
                    widx++; pending = 0;
                end
            end else begin
                wr_ack = 1'b0;
            end
            @(negedge clk);
        end
        byte_valid = 1'b0; wr_ack = 1'b0; wr_pass = 1'b0;
        check(seen_done, "R11 done seen", seen_done, 1);
        check(side_ok, "R10 hold/byte_ready", side_ok, 1);
        check(widx == ((fail_at < nwords) ? fail_at + 1 : nwords), "R1/R5/R7 word count",
              widx, (fail_at < nwords) ? fail_at + 1 : nwords);
        check(status == ((fail_at < nwords) ? 2'b01 : 2'b00), "R7/R11 status", status,
              (fail_at < nwords) ? 1 : 0);
        check(byte_count == LEN_W'(exp_cnt), "R6 byte_count", byte_count, exp_cnt);
        check(req_ready, "R11 idle after done", req_ready, 1);
        @(negedge clk);
        check(!done, "R11 done one cycle", done, 0);
    endtask

    task automatic run_reject(int a, int l, logic [1:0] exp_st, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = ADDR_W'(a); req_len = LEN_W'(l);
        @(negedge clk);
        req_valid = 1'b0;
        check(done, tag, done, 1);
        check(status == exp_st, tag, status, exp_st);
        check(byte_count == '0, tag, byte_count, 0);
        check(!wr_req && !byte_ready, tag, wr_req, 0);
        @(negedge clk);
        check(!done && !wr_req && req_ready, tag, done, 0);
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(req_ready && !wr_req && !done && !byte_ready, "R11 reset outputs", wr_req, 0);
        check(byte_count == '0 && status == 2'b00, "R11 reset count/status", byte_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            run_req(int'(VEC[v][31:16]), int'(VEC[v][15:4]),
                    (VEC[v][3:0] == 4'hF) ? 99 : int'(VEC[v][3:0]), v);
        end
        run_reject(100, 0, 2'b00, "R8 zero length");
        run_reject(4094, 3, 2'b10, "R9 overrun");
        run_reject(4096, 1, 2'b10, "R9 start at end");
        run_req(4092, 4, 99, 50);   // R9 last full word accepted
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule